// File: doc/BRIEF.md
# In-Place Radix-2 FFT Address Sequencer

This block drives the address side of an in-place radix-2 decimation-in-time FFT over 2^LOG2_N points (1024 by default). After a start request it steps through every butterfly of the transform. For each one it presents a top address, a bottom address and a twiddle exponent to a butterfly datapath under a valid/ready handshake. The arithmetic, the data memory, the twiddle source and the input bit-reversal lie outside the block.

Three nested counters walk the transform. The outer counter selects the stage. The middle counter selects the flight, which is the set of butterflies that share one twiddle. The inner counter steps through the butterflies of that flight. Every butterfly of one flight is issued back to back, so the twiddle value changes only once per flight. A small flow controller starts the run, reports stage boundaries and signals completion.

Top module: `fft_addr_seq`

## Requirements
- R1: While rst_ni is low and after reset, bfly_valid_o, busy_o, stage_end_o and done_o are 0.
- R2: A start_i sampled high while idle sets busy_o and bfly_valid_o from the next cycle on. The first butterfly issued is top 0, bottom 1, twiddle 0. bfly_valid_o then stays high until the last butterfly is accepted.
- R3: Butterflies are issued in nested-loop order. Stage s runs from 0 to LOG2_N-1 with span n1 = 2^s and group size n2 = 2^(s+1). Within a stage the flight j runs from 0 to n1-1. Within a flight k runs from j in steps of n2 while k < N. Each butterfly gives top_addr_o = k and bot_addr_o = k + n1.
- R4: twid_exp_o equals j·(N/n2), which is j shifted left by LOG2_N-1-s, in units of 2π/N.
- R5: While bfly_valid_o is high and bfly_ready_i is low, the butterfly outputs hold their values and no butterfly is skipped.
- R6: stage_o carries the current stage number s. stage_start_o is high exactly while the first butterfly (j = 0, k = 0) of a stage is presented.
- R7: stage_end_o pulses for one cycle, in the cycle after the handshake of the last butterfly of each stage. Each stage issues N/2 butterflies.
- R8: After the handshake of butterfly number LOG2_N·N/2 (the last one of the final stage), done_o pulses in the same cycle as that stage's stage_end_o. In that cycle busy_o and bfly_valid_o are already 0.
- R9: start_i has no effect while busy_o is high. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a transform (only while idle) |
| bfly_valid_o | output | 1 | Butterfly descriptor valid |
| bfly_ready_i | input | 1 | Datapath accepts the descriptor |
| top_addr_o | output | LOG2_N | Top data address k |
| bot_addr_o | output | LOG2_N | Bottom data address k+n1 |
| twid_exp_o | output | LOG2_N-1 | Twiddle exponent |
| stage_o | output | $clog2(LOG2_N) | Current stage number |
| stage_start_o | output | 1 | First butterfly of a stage is presented |
| stage_end_o | output | 1 | One-cycle pulse after a stage's last handshake |
| done_o | output | 1 | One-cycle pulse at the end of the transform |
| busy_o | output | 1 | Transform in progress |

## Verification
Two events fall in the same cycle: the end of the final stage and the completion of the transform. This happens after the 5120th handshake. The bench throttles bfly_ready_i at random, so the last handshake arrives after a varying stall, and then expects stage_end_o and done_o both high one cycle later, with valid and busy low. A start request raised partway through a run must not disturb the order. The bench checks this by comparing every accepted triple with a table built from the nested loops.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/fft_stage_ctrl.sv
module fft_stage_ctrl #(
  parameter int LOG2_N = 10,
  localparam int AW = LOG2_N,
  localparam int SW = $clog2(LOG2_N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          step_i,
  output logic [SW-1:0] stage_o,
  output logic [AW-1:0] n1_o,
  output logic [AW:0]   n2_o,
  output logic          last_o
);
  logic [SW-1:0] stage_q;

  assign last_o  = (stage_q == SW'(LOG2_N - 1));
  assign n1_o    = AW'(1) << stage_q;
  assign n2_o    = {n1_o, 1'b0};
  assign stage_o = stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= '0;
    else if (init_i)  stage_q <= '0;
    else if (step_i)  stage_q <= last_o ? '0 : stage_q + SW'(1);
  end
endmodule

// File: rtl/fft_flight_ctrl.sv
module fft_flight_ctrl #(
  parameter int LOG2_N = 10,
  localparam int AW = LOG2_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          step_i,
  input  logic [AW-1:0] n1_i,
  output logic [AW-1:0] j_o,
  output logic [AW-1:0] j_next_o,
  output logic          last_o
);
  logic [AW-1:0] j_q;

  assign last_o   = (j_q == n1_i - AW'(1));
  assign j_next_o = last_o ? '0 : j_q + AW'(1);
  assign j_o      = j_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      j_q <= '0;
    else if (init_i)  j_q <= '0;
    else if (step_i)  j_q <= j_next_o;
  end
endmodule

// File: rtl/fft_bfly_ctrl.sv
module fft_bfly_ctrl #(
  parameter int LOG2_N = 10,
  localparam int AW = LOG2_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          step_i,
  input  logic [AW:0]   n2_i,
  input  logic [AW-1:0] reload_i,
  output logic [AW-1:0] k_o,
  output logic          last_o
);
  logic [AW-1:0] k_q;
  logic [AW:0]   k_sum;

  // carry out of k+n2 marks the last butterfly of a flight
  assign k_sum  = {1'b0, k_q} + n2_i;
  assign last_o = k_sum[AW];
  assign k_o    = k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      k_q <= '0;
    else if (init_i)  k_q <= '0;
    else if (step_i)  k_q <= last_o ? reload_i : k_sum[AW-1:0];
  end
endmodule

// File: rtl/fft_seq_flow.sv
module fft_seq_flow
  import fft_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stage_wrap_i,
  input  logic final_i,
  output logic run_o,
  output logic init_o,
  output logic stage_end_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic       stage_end_q, done_q;

  assign init_o = (state_q == SEQ_IDLE) && start_i;
  assign run_o  = (state_q == SEQ_RUN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (start_i) state_d = SEQ_RUN;
      SEQ_RUN:  if (final_i) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_IDLE;
      stage_end_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      stage_end_q <= stage_wrap_i;
      done_q      <= final_i;
    end
  end

  assign stage_end_o = stage_end_q;
  assign done_o      = done_q;
endmodule

// File: rtl/fft_addr_seq.sv
module fft_addr_seq #(
  parameter int LOG2_N = 10,
  localparam int AW = LOG2_N,
  localparam int TW = LOG2_N - 1,
  localparam int SW = $clog2(LOG2_N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          bfly_valid_o,
  input  logic          bfly_ready_i,
  output logic [AW-1:0] top_addr_o,
  output logic [AW-1:0] bot_addr_o,
  output logic [TW-1:0] twid_exp_o,
  output logic [SW-1:0] stage_o,
  output logic          stage_start_o,
  output logic          stage_end_o,
  output logic          done_o,
  output logic          busy_o
);
  logic          run, init, adv;
  logic          last_k, last_j, last_s;
  logic          flight_step, stage_step, final_bfly;
  logic [AW-1:0] n1, j, j_next, k;
  logic [AW:0]   n2;
  logic [SW-1:0] shamt;

  assign adv         = run && bfly_ready_i;
  assign flight_step = adv && last_k;
  assign stage_step  = flight_step && last_j;
  assign final_bfly  = stage_step && last_s;

  fft_seq_flow u_flow (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .stage_wrap_i (stage_step),
    .final_i      (final_bfly),
    .run_o        (run),
    .init_o       (init),
    .stage_end_o  (stage_end_o),
    .done_o       (done_o)
  );

  fft_stage_ctrl #(.LOG2_N(LOG2_N)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init),
    .step_i  (stage_step),
    .stage_o (stage_o),
    .n1_o    (n1),
    .n2_o    (n2),
    .last_o  (last_s)
  );

  fft_flight_ctrl #(.LOG2_N(LOG2_N)) u_flight (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (init),
    .step_i   (flight_step),
    .n1_i     (n1),
    .j_o      (j),
    .j_next_o (j_next),
    .last_o   (last_j)
  );

  fft_bfly_ctrl #(.LOG2_N(LOG2_N)) u_bfly (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (init),
    .step_i   (adv),
    .n2_i     (n2),
    .reload_i (j_next),
    .k_o      (k),
    .last_o   (last_k)
  );

  // j < 2^s, so j << (LOG2_N-1-s) stays below N/2
  assign shamt         = SW'(LOG2_N - 1) - stage_o;
  assign twid_exp_o    = j[TW-1:0] << shamt;
  assign top_addr_o    = k;
  assign bot_addr_o    = k + n1;
  assign bfly_valid_o  = run;
  assign busy_o        = run;
  assign stage_start_o = run && (j == '0) && (k == '0);
endmodule

// File: rtl/fft_addr_seq_chk.sv
module fft_addr_seq_chk #(
  parameter int LOG2_N = 10,
  localparam int AW = LOG2_N,
  localparam int TW = LOG2_N - 1,
  localparam int SW = $clog2(LOG2_N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          bfly_valid_o,
  input logic          bfly_ready_i,
  input logic [AW-1:0] top_addr_o,
  input logic [AW-1:0] bot_addr_o,
  input logic [TW-1:0] twid_exp_o,
  input logic [SW-1:0] stage_o,
  input logic          stage_start_o,
  input logic          stage_end_o,
  input logic          done_o,
  input logic          busy_o
);
  logic [AW-1:0] span;
  assign span = bot_addr_o - top_addr_o;

  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!bfly_valid_o && !busy_o && !done_o && !stage_end_o); // R1
  end

  AST_START_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> bfly_valid_o && top_addr_o == '0 && twid_exp_o == '0); // R2
  AST_SPAN_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bfly_valid_o |-> $onehot(span) && bot_addr_o > top_addr_o); // R3
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bfly_valid_o && !bfly_ready_i |=> bfly_valid_o && $stable(top_addr_o) &&
    $stable(bot_addr_o) && $stable(twid_exp_o) && $stable(stage_o)); // R5
  AST_STAGE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_start_o |-> bfly_valid_o && top_addr_o == '0 && twid_exp_o == '0); // R6
  AST_END_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_end_o |=> !stage_end_o); // R7
  AST_DONE_WITH_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> stage_end_o && !busy_o && !bfly_valid_o); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(bfly_valid_o && bfly_ready_i) |=> busy_o); // R9
endmodule

bind fft_addr_seq fft_addr_seq_chk #(.LOG2_N(LOG2_N)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .bfly_valid_o  (bfly_valid_o),
  .bfly_ready_i  (bfly_ready_i),
  .top_addr_o    (top_addr_o),
  .bot_addr_o    (bot_addr_o),
  .twid_exp_o    (twid_exp_o),
  .stage_o       (stage_o),
  .stage_start_o (stage_start_o),
  .stage_end_o   (stage_end_o),
  .done_o        (done_o),
  .busy_o        (busy_o)
);

// File: tb/fft_addr_seq_bench.sv
module fft_addr_seq_bench;
  localparam int LOG2_N = 10;
  localparam int N      = 1 << LOG2_N;
  localparam int PER    = N / 2;
  localparam int TOTAL  = LOG2_N * PER;

  logic       clk_i = 1'b0;
  logic       rst_ni, start_i, bfly_ready_i;
  logic       bfly_valid_o, stage_start_o, stage_end_o, done_o, busy_o;
  logic [9:0] top_addr_o, bot_addr_o;
  logic [8:0] twid_exp_o;
  logic [3:0] stage_o;

  int checks = 0, failures = 0, cycles = 0;
  int exp_top [TOTAL];
  int exp_bot [TOTAL];
  int exp_tw  [TOTAL];

  always #2 clk_i = ~clk_i;

  fft_addr_seq #(.LOG2_N(LOG2_N)) u_fft_addr_seq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_ref();
    int idx = 0;
    int n1, n2 = 1;
    for (int s = 0; s < LOG2_N; s++) begin
      n1 = n2;
      n2 = n2 + n2;
      for (int j = 0; j < n1; j++)
        for (int k = j; k < N; k += n2) begin
          exp_top[idx] = k;
          exp_bot[idx] = k + n1;
          exp_tw[idx]  = j * (N / n2);
          idx++;
        end
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input int pct, input bit inject);
    int idx = 0;
    bit se_p = 0, dn_p = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk(bfly_valid_o && busy_o, "R2 valid after start", int'(bfly_valid_o), 1);
    chk(top_addr_o == 0 && bot_addr_o == 1 && twid_exp_o == 0, "R2 first triple",
        int'(bot_addr_o), 1);
    while (idx < TOTAL) begin
      chk(stage_end_o == se_p, "R7 stage_end", int'(stage_end_o), int'(se_p));
      chk(done_o == dn_p, "R8 done", int'(done_o), int'(dn_p));
      se_p = 0;
      dn_p = 0;
      start_i = (inject && idx == 700);  // R9: ignored while busy
      chk(busy_o == 1'b1, "R9 busy during run", int'(busy_o), 1);
      bfly_ready_i = ($urandom % 100) < pct;
      if (bfly_valid_o) begin
        chk(int'(top_addr_o) == exp_top[idx], "R3 top", int'(top_addr_o), exp_top[idx]);
        chk(int'(bot_addr_o) == exp_bot[idx], "R3 bottom", int'(bot_addr_o), exp_bot[idx]);
        chk(int'(twid_exp_o) == exp_tw[idx], "R4 twiddle", int'(twid_exp_o), exp_tw[idx]);
        chk(int'(stage_o) == idx / PER, "R6 stage", int'(stage_o), idx / PER);
        chk(stage_start_o == (idx % PER == 0), "R6 stage_start", int'(stage_start_o),
            int'(idx % PER == 0));
        if (bfly_ready_i) begin
          if (idx % PER == PER - 1) se_p = 1;
          if (idx == TOTAL - 1) dn_p = 1;
          idx++;
        end  // else R5: next pass compares the same expected triple
      end else begin
        chk(1'b0, "R2 valid held", 0, 1);
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    bfly_ready_i = 1'b0;
    chk(stage_end_o == 1'b1, "R7 last stage_end", int'(stage_end_o), 1);
    chk(done_o == 1'b1, "R8 done with stage_end", int'(done_o), 1);
    chk(!busy_o && !bfly_valid_o, "R8 idle at done", int'(busy_o), 0);
    @(negedge clk_i);
    chk(!done_o && !stage_end_o, "R8 done single pulse", int'(done_o), 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20110228);
    rst_ni = 1'b0;
    start_i = 1'b0;
    bfly_ready_i = 1'b0;
    build_ref();
    repeat (3) @(negedge clk_i);
    chk(!bfly_valid_o && !busy_o, "R1 reset valid/busy", int'(bfly_valid_o), 0);
    chk(!done_o && !stage_end_o, "R1 reset pulses", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!bfly_valid_o && !busy_o, "R1 idle after reset", int'(busy_o), 0);
    run(70, 1'b1);
    run(100, 1'b0);
    run(25, 1'b1);
    repeat (4) @(negedge clk_i);
    chk(!bfly_valid_o && !busy_o, "R8 stays idle", int'(bfly_valid_o), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule